// File: doc/BRIEF.md
# Seconds Counter with Alarm

A register-mapped seconds counter for an always-on domain. A 32-bit count advances once per one-second tick, delivered as a single-cycle strobe on `tick_i`, while the count enable is set. Software loads the count, programs one alarm value and gets a level interrupt when the count reaches that value. Two strobe inputs from an external trimming circuit can drop a tick or add one extra count on a tick, so the time base can be corrected without touching the count through the bus.

The bus side is a simple single-cycle slave. A request with `we_i` high writes `wdata_i` at the word offset on `addr_i`. A request with `we_i` low returns read data on `rdata_o` in the same cycle. A build parameter selects Gray coding for the stored count and alarm. In that mode the bus writes and reads Gray codes, and the block decodes them internally so that it can count and compare in binary.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset every register reads zero, the count does not advance and `irq_o` is low.
- R2: The control register sits at word offset 0x0. Bit 12 enables counting, bit 8 selects the oscillator source and drives `osc_sel_o`, and bit 0 enables the alarm. Every other bit reads 0.
- R3: A write to offset 0x1 replaces the count in the next cycle. It takes priority over a tick in the same cycle.
- R4: With counting enabled, each tick adds one to the count. With counting disabled, the count holds. The count wraps from 0xFFFFFFFF to 0. Offset 0xD returns the live count.
- R5: On a tick with counting enabled, `skip_i` alone adds 0, `ins_i` alone adds 2, and both together add 1. Without a tick, or with counting disabled, the strobes have no effect.
- R6: The alarm status, bit 0 at offset 0xC, is set on a tick when the alarm enable is 1 and the count before that tick equals the alarm register at offset 0x2. With the alarm enable at 0, it is not set.
- R7: `irq_o` is high exactly when the status is 1 and bit 0 of the mask register at offset 0x8 is 0. Masking does not change the status.
- R8: Writing 1 to bit 0 at offset 0x9 clears the status, and writing 0 there has no effect. If a set and a clear fall in the same cycle, the status ends up set.
- R9: With `GRAY_STORE`=1, the values written to 0x1 and 0x2 and the value read from 0xD and 0x2 are Gray codes, g = b ^ (b >> 1). Counting and matching follow the binary sequence.
- R10: Offsets 0x1, 0x9 and unmapped offsets read 0. Writes to 0xC, 0xD and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| skip_i | input | 1 | Drop the advance of this tick |
| ins_i | input | 1 | Add one extra count on this tick |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | AW | Word offset |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid in the request cycle |
| osc_sel_o | output | 1 | Oscillator source select |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
A wrong count shows up on the next live-time read, and it stays wrong on every later read, because each tick adds to the corrupted value. A wrong count also moves the alarm: the interrupt then comes one or more ticks early or late, or never. A status flip-flop that fails to set or clear changes `irq_o` in the cycle after the faulty edge. Because of this, the bench compares `irq_o` and the read data against its model every cycle. In Gray mode, a decode fault corrupts the value after the first increment even when the loaded value itself reads back correctly.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam logic [3:0] OFF_CTRL   = 4'h0;
  localparam logic [3:0] OFF_LOAD   = 4'h1;
  localparam logic [3:0] OFF_ALARM  = 4'h2;
  localparam logic [3:0] OFF_MASK   = 4'h8;
  localparam logic [3:0] OFF_CLEAR  = 4'h9;
  localparam logic [3:0] OFF_STATUS = 4'hC;
  localparam logic [3:0] OFF_LIVE   = 4'hD;

  localparam int unsigned BIT_ALM_EN  = 0;
  localparam int unsigned BIT_OSC_SEL = 8;
  localparam int unsigned BIT_CNT_EN  = 12;

  typedef struct packed {
    logic cnt_en;
    logic osc_sel;
    logic alm_en;
  } ctrl_t;
endpackage

// File: rtl/sa_gray_dec.sv
module sa_gray_dec #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] g_i,
  output logic [W-1:0] b_o
);
  assign b_o[W-1] = g_i[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_bit
    assign b_o[i] = b_o[i+1] ^ g_i[i];
  end
endmodule

// File: rtl/sa_regs.sv
module sa_regs
  import sa_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_raw_i,
  input  logic          status_i,
  output ctrl_t         ctrl_o,
  output logic          mask_o,
  output logic [DW-1:0] alarm_raw_o,
  output logic          load_o,
  output logic          clr_o,
  output logic [DW-1:0] rdata_o
);
  logic          wr, rd;
  ctrl_t         ctrl_q;
  logic          mask_q;
  logic [DW-1:0] alarm_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mask_q  <= 1'b0;
      alarm_q <= '0;
    end else if (wr) begin
      if (addr_i == AW'(OFF_CTRL)) begin
        ctrl_q.cnt_en  <= wdata_i[BIT_CNT_EN];
        ctrl_q.osc_sel <= wdata_i[BIT_OSC_SEL];
        ctrl_q.alm_en  <= wdata_i[BIT_ALM_EN];
      end
      if (addr_i == AW'(OFF_MASK))  mask_q  <= wdata_i[0];
      if (addr_i == AW'(OFF_ALARM)) alarm_q <= wdata_i;
    end
  end

  assign load_o      = wr && (addr_i == AW'(OFF_LOAD));
  assign clr_o       = wr && (addr_i == AW'(OFF_CLEAR)) && wdata_i[0];
  assign ctrl_o      = ctrl_q;
  assign mask_o      = mask_q;
  assign alarm_raw_o = alarm_q;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        AW'(OFF_CTRL): begin
          rdata_o[BIT_CNT_EN]  = ctrl_q.cnt_en;
          rdata_o[BIT_OSC_SEL] = ctrl_q.osc_sel;
          rdata_o[BIT_ALM_EN]  = ctrl_q.alm_en;
        end
        AW'(OFF_ALARM):  rdata_o = alarm_q;
        AW'(OFF_MASK):   rdata_o[0] = mask_q;
        AW'(OFF_STATUS): rdata_o[0] = status_i;
        AW'(OFF_LIVE):   rdata_o = cnt_raw_i;
        default:         rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sa_counter.sv
module sa_counter #(
  parameter int unsigned DW         = 32,
  parameter bit          GRAY_STORE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          skip_i,
  input  logic          ins_i,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] bin_o
);
  logic [DW-1:0] raw_q, bin, nxt_bin, nxt_raw;
  logic [1:0]    step;
  logic          adv;

  assign adv = tick_i & en_i;

  if (GRAY_STORE) begin : g_gray
    sa_gray_dec #(.W(DW)) u_dec (.g_i(raw_q), .b_o(bin));
    assign nxt_raw = nxt_bin ^ (nxt_bin >> 1);
  end else begin : g_bin
    assign bin     = raw_q;
    assign nxt_raw = nxt_bin;
  end

  // skip and insert cancel when both present
  always_comb begin
    unique case ({ins_i, skip_i})
      2'b01:   step = 2'd0;
      2'b10:   step = 2'd2;
      default: step = 2'd1;
    endcase
  end

  assign nxt_bin = bin + DW'(step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= '0;
    else if (load_i) raw_q <= load_val_i;
    else if (adv)    raw_q <= nxt_raw;
  end

  assign raw_o = raw_q;
  assign bin_o = bin;
endmodule

// File: rtl/sa_alarm.sv
module sa_alarm #(
  parameter int unsigned DW         = 32,
  parameter bit          GRAY_STORE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          alm_en_i,
  input  logic          mask_i,
  input  logic          clr_i,
  input  logic [DW-1:0] cnt_bin_i,
  input  logic [DW-1:0] alarm_raw_i,
  output logic          status_o,
  output logic          irq_o
);
  logic [DW-1:0] alarm_bin;
  logic          hit, status_q;

  if (GRAY_STORE) begin : g_gray
    sa_gray_dec #(.W(DW)) u_dec (.g_i(alarm_raw_i), .b_o(alarm_bin));
  end else begin : g_bin
    assign alarm_bin = alarm_raw_i;
  end

  assign hit = tick_i & alm_en_i & (cnt_bin_i == alarm_bin);

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= 1'b0;
    else if (hit)   status_q <= 1'b1;
    else if (clr_i) status_q <= 1'b0;
  end

  assign status_o = status_q;
  assign irq_o    = status_q & ~mask_i;
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sa_pkg::*;
#(
  parameter int unsigned AW         = 4,
  parameter int unsigned DW         = 32,
  parameter bit          GRAY_STORE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          skip_i,
  input  logic          ins_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          osc_sel_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          mask, load, clr, status;
  logic [DW-1:0] alarm_raw, cnt_raw, cnt_bin;

  sa_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_raw_i  (cnt_raw),
    .status_i   (status),
    .ctrl_o     (ctrl),
    .mask_o     (mask),
    .alarm_raw_o(alarm_raw),
    .load_o     (load),
    .clr_o      (clr),
    .rdata_o    (rdata_o)
  );

  sa_counter #(.DW(DW), .GRAY_STORE(GRAY_STORE)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .skip_i    (skip_i),
    .ins_i     (ins_i),
    .en_i      (ctrl.cnt_en),
    .load_i    (load),
    .load_val_i(wdata_i),
    .raw_o     (cnt_raw),
    .bin_o     (cnt_bin)
  );

  sa_alarm #(.DW(DW), .GRAY_STORE(GRAY_STORE)) u_alm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .alm_en_i   (ctrl.alm_en),
    .mask_i     (mask),
    .clr_i      (clr),
    .cnt_bin_i  (cnt_bin),
    .alarm_raw_i(alarm_raw),
    .status_o   (status),
    .irq_o      (irq_o)
  );

  assign osc_sel_o = ctrl.osc_sel;
endmodule

// File: rtl/sa_checker.sv
module sa_checker
  import sa_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          tick_i,
  input logic          skip_i,
  input logic          ins_i,
  input logic          cnt_en,
  input logic          alm_en,
  input logic [DW-1:0] cnt_raw,
  input logic          status
);
  logic load_wr, clr_wr;
  assign load_wr = req_i && we_i && (addr_i == AW'(OFF_LOAD));
  assign clr_wr  = req_i && we_i && (addr_i == AW'(OFF_CLEAR)) && wdata_i[0];

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr |=> cnt_raw == $past(wdata_i));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_wr && !cnt_en) |=> $stable(cnt_raw));

  assert_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_wr && tick_i && skip_i && !ins_i) |=> $stable(cnt_raw));

  assert_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status) |-> $past(tick_i && alm_en));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !tick_i) |=> !status);
endmodule

bind sec_alarm_timer sa_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .tick_i (tick_i),
  .skip_i (skip_i),
  .ins_i  (ins_i),
  .cnt_en (ctrl.cnt_en),
  .alm_en (ctrl.alm_en),
  .cnt_raw(cnt_raw),
  .status (status)
);

// File: tb/sec_alarm_timer_tb.sv
module sec_alarm_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, skip = 1'b0, ins = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = 4'hD;
  logic [31:0] wdata_p = '0, wdata_g;
  logic [31:0] rdata_p, rdata_g;
  logic        irq_p, irq_g, osc_p, osc_g;

  int n_chk = 0;
  int n_err = 0;

  function automatic logic [31:0] b2g(input logic [31:0] v);
    return v ^ (v >> 1);
  endfunction

  assign wdata_g = (addr == 4'h1 || addr == 4'h2) ? b2g(wdata_p) : wdata_p;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sec_alarm_timer #(.GRAY_STORE(1'b0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .skip_i(skip), .ins_i(ins),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata_p),
    .rdata_o(rdata_p), .osc_sel_o(osc_p), .irq_o(irq_p));

  sec_alarm_timer #(.GRAY_STORE(1'b1)) u_dut_gray (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .skip_i(skip), .ins_i(ins),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata_g),
    .rdata_o(rdata_g), .osc_sel_o(osc_g), .irq_o(irq_g));

  // reference model, binary values
  logic [31:0] m_cnt, m_alarm, n_cnt;
  logic        m_cen, m_osc, m_aen, m_mask, m_st, m_set;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_alarm = 0; m_cen = 0; m_osc = 0; m_aen = 0; m_mask = 0; m_st = 0;
    end else begin
      m_set = tick && m_aen && (m_cnt == m_alarm);
      n_cnt = m_cnt;
      if (tick && m_cen) n_cnt = m_cnt + 32'(ins) + 32'(!skip);
      if (req && we) begin
        case (addr)
          4'h0: begin m_cen = wdata_p[12]; m_osc = wdata_p[8]; m_aen = wdata_p[0]; end
          4'h1: n_cnt = wdata_p;
          4'h2: m_alarm = wdata_p;
          4'h8: m_mask = wdata_p[0];
          default: ;
        endcase
      end
      if (m_set) m_st = 1'b1;
      else if (req && we && addr == 4'h9 && wdata_p[0]) m_st = 1'b0;
      m_cnt = n_cnt;
    end
  end

  function automatic logic [31:0] enc(input logic [3:0] a, input logic [31:0] v, input bit g);
    return (g && (a == 4'h2 || a == 4'hD)) ? b2g(v) : v;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a, input bit g);
    logic [31:0] v = '0;
    case (a)
      4'h0: begin v[12] = m_cen; v[8] = m_osc; v[0] = m_aen; end
      4'h2: v = enc(a, m_alarm, g);
      4'h8: v[0] = m_mask;
      4'hC: v[0] = m_st;
      4'hD: v = enc(a, m_cnt, g);
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    #2;
    if (rst_ni) begin
      check("R7 irq", {31'b0, irq_p}, {31'b0, m_st & ~m_mask});
      check("R9 irq", {31'b0, irq_g}, {31'b0, m_st & ~m_mask});
      check("R2 osc", {31'b0, osc_p}, {31'b0, m_osc});
      if (req && !we) begin
        check("R4 read", rdata_p, exp_rd(addr, 1'b0));
        check("R9 read", rdata_g, exp_rd(addr, 1'b1));
      end
    end
  end

  task automatic drive(input logic r, input logic w, input logic [3:0] a,
                       input logic [31:0] d, input logic t, input logic s, input logic i);
    @(negedge clk_i);
    req = r; we = w; addr = a; wdata_p = d; tick = t; skip = s; ins = i;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive(1, 1, a, d, 0, 0, 0);
  endtask

  task automatic wr_tk(input logic [3:0] a, input logic [31:0] d);
    drive(1, 1, a, d, 1, 0, 0);
  endtask

  task automatic tk(input logic s, input logic i);
    drive(1, 0, 4'hD, 0, 1, s, i);
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] v, input string tag);
    drive(1, 0, a, 0, 0, 0, 0);
    #1;
    check(tag, rdata_p, enc(a, v, 1'b0));
    check({tag, " R9"}, rdata_g, enc(a, v, 1'b1));
  endtask

  task automatic chk_irq(input logic e, input string tag);
    drive(1, 0, 4'hD, 0, 0, 0, 0);
    #1;
    check(tag, {31'b0, irq_p}, {31'b0, e});
    check(tag, {31'b0, irq_g}, {31'b0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk_rd(4'h0, 0, "R1"); chk_rd(4'hD, 0, "R1"); chk_rd(4'h2, 0, "R1");
    chk_rd(4'hC, 0, "R1"); chk_rd(4'h8, 0, "R1"); chk_irq(0, "R1");
    tk(0, 0); chk_rd(4'hD, 0, "R4 disabled");
    // R2 control fields
    wr(4'h0, 32'h1100); chk_rd(4'h0, 32'h1100, "R2");
    check("R2 osc_sel", {31'b0, osc_p}, 32'h1);
    wr(4'h0, 32'hFFFF_FFFF); chk_rd(4'h0, 32'h1101, "R2 reserved");
    wr(4'h0, 32'h1000);
    // R3/R4 load and count
    wr(4'h1, 100); chk_rd(4'hD, 100, "R3");
    tk(0, 0); tk(0, 0); tk(0, 0); chk_rd(4'hD, 103, "R4");
    wr_tk(4'h1, 500); chk_rd(4'hD, 500, "R3 priority");
    // R5 strobes
    tk(1, 0); chk_rd(4'hD, 500, "R5 skip");
    tk(0, 1); chk_rd(4'hD, 502, "R5 insert");
    tk(1, 1); chk_rd(4'hD, 503, "R5 both");
    drive(1, 0, 4'hD, 0, 0, 0, 1); chk_rd(4'hD, 503, "R5 no tick");
    wr(4'h0, 0); tk(0, 1); chk_rd(4'hD, 503, "R5 disabled");
    wr(4'h0, 32'h1000);
    // R6 alarm enable off
    wr(4'h2, 505); chk_rd(4'h2, 505, "R6");
    tk(0, 0); tk(0, 0); tk(0, 0); chk_rd(4'hC, 0, "R6 alarm off");
    // R6/R7 fire
    wr(4'h1, 505); wr(4'h0, 32'h1001); tk(0, 0);
    chk_rd(4'hC, 1, "R6 set"); chk_irq(1, "R7 irq");
    wr(4'h8, 1); chk_irq(0, "R7 masked"); chk_rd(4'hC, 1, "R7 status kept");
    // R8 clear
    wr(4'h9, 0); chk_rd(4'hC, 1, "R8 zero write");
    wr(4'h9, 1); chk_rd(4'hC, 0, "R8 clear");
    wr(4'h8, 0);
    wr(4'h1, 700); wr(4'h2, 700); wr_tk(4'h9, 1);
    chk_rd(4'hC, 1, "R8 set wins"); chk_irq(1, "R7");
    wr(4'h9, 1); chk_irq(0, "R8");
    // R4 wrap and match at top
    wr(4'h1, 32'hFFFF_FFFF); wr(4'h2, 32'hFFFF_FFFF); tk(0, 0);
    chk_rd(4'hD, 0, "R4 wrap"); chk_rd(4'hC, 1, "R6 top");
    wr(4'h9, 1);
    // R10 ignored writes and zero reads
    wr(4'h5, 32'hFFFF); chk_rd(4'h5, 0, "R10");
    chk_rd(4'h1, 0, "R10"); chk_rd(4'h9, 0, "R10");
    chk_rd(4'h0, 32'h1001, "R10"); chk_rd(4'h2, 32'hFFFF_FFFF, "R10");
    wr(4'hD, 1234); chk_rd(4'hD, 0, "R10 live");
    wr(4'hC, 0); chk_rd(4'hC, 0, "R10 status");
    // R9 gray sequence
    wr(4'h1, 7); tk(0, 0); chk_rd(4'hD, 8, "R9");
    wr(4'h1, 32'h7FFF_FFFF); tk(0, 0); chk_rd(4'hD, 32'h8000_0000, "R9");
    // mixed traffic against model
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (lf[2:0])
          3'd0: wr(4'h2, m_cnt + 32'(lf[5:4]));
          3'd1: wr(4'h9, 32'(lf[6]));
          3'd2: wr(4'h8, 32'(lf[7]));
          3'd3: wr(4'h0, {19'b0, lf[8], 3'b0, lf[9], 7'b0, 1'b1});
          default: tk(lf[11], lf[12]);
        endcase
      end
    end
    chk_rd(4'hD, m_cnt, "R4 final");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule